// File: doc/BRIEF.md
# Fuse Row Controller with Programming Unlock

This block controls a small one-time-programmable fuse array through a 32-bit register interface. Each row holds 41 bits: 32 data bits and 9 check bits. Software places a row number, operand words and a command code in registers. It raises a start bit, polls a completion flag, then clears that flag by writing a one to it. The block carries out three commands: read a row, take one step of the programming unlock, and program a row.

Programming is guarded. A row can be programmed only after four program-enable commands have supplied the words 0xF, 0x4, 0x8 and 0xD in that order. A wrong word sends the unlock back to its first step. Fuse cells only ever go from 0 to 1, so each program command ORs new bits into the row. A read raises an error-detect flag when checking is enabled and the row's stored check bits are not all zero. The check code itself is left to software.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the ready flag (status word bit 3) reads 0 for INIT_CYCLES clocks and then reads 1 for good. No command starts while it is 0.
- R2: The access register holds CPU-enable (bit 15), check-disable (bit 9) and check-write-enable (bit 8). While CPU-enable is 0, a start request has no effect: no completion flag and no change to the array or the read registers.
- R3: A command starts only on a 0-to-1 change of the start bit (command register bit 0). The command code sits in bits 4:1. When the command finishes, completion (status-B bit 1) reads 1, and writing 1 to that bit clears it. Holding start high does not start the command again.
- R4: Read (code 0) takes the row from row-address register bits 15:6. It returns the 32 data bits in read word 0 and the 9 check bits in bits 8:0 of read word 1.
- R5: Program-enable (code 2) commands whose write word 0 carries 0xF, 0x4, 0x8 and 0xD in that order set program-OK (status word bit 2). Any wrong word sends the unlock back to its first step.
- R6: Writing 0 to CPU-enable clears program-OK and the unlock progress.
- R7: A program-word command (code 10) issued while program-OK is 0 still sets completion, but it leaves the array unchanged.
- R8: A program-word command with program-OK set ORs write word 0 into the row's data bits. When check-write-enable is 1 it also ORs bits 8:0 of write word 1 into the check bits; otherwise the check bits stay as they were. Bits never clear.
- R9: Each read updates error-detect (status-B bit 17). It sets the flag to 1 when check-disable is 0 and the row's check bits are nonzero, and clears it otherwise.
- R10: A row number of ROWS or more reads as all zero, and a program command to such a row has no effect.
- R11: Word addresses: access 0, row address 1, write word 0 at 2, write word 1 at 3, command 4, status 5, status-B 6, read word 0 at 7, read word 1 at 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |

## Verification
The hardest state to reach from the ports is an unlock that has partly advanced and is then thrown off. One case is a correct prefix followed by a word that would be valid at a different step. The bench runs directed sequences for this, such as F,4,F,4,8,D, which must leave program-OK low. It then drops CPU-enable after a full unlock and checks that program commands are refused. Randomized program and read mixes follow, over rows inside and outside the array and with the check-bit controls flipped at random. A bench model of OR-only fuses predicts every readback.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int DATA_W = 32;
  localparam int CHK_W  = 9;
  localparam int ROW_W  = DATA_W + CHK_W;
  localparam int RADDR_W = 10;
  localparam int RADDR_LSB = 6;

  localparam logic [3:0] CMD_READ      = 4'd0;
  localparam logic [3:0] CMD_PROG_EN   = 4'd2;
  localparam logic [3:0] CMD_PROG_WORD = 4'd10;

  localparam logic [3:0] REG_ACC = 4'd0;
  localparam logic [3:0] REG_ROW = 4'd1;
  localparam logic [3:0] REG_WD0 = 4'd2;
  localparam logic [3:0] REG_WD1 = 4'd3;
  localparam logic [3:0] REG_CMD = 4'd4;
  localparam logic [3:0] REG_ST  = 4'd5;
  localparam logic [3:0] REG_STB = 4'd6;
  localparam logic [3:0] REG_RD0 = 4'd7;
  localparam logic [3:0] REG_RD1 = 4'd8;

  localparam int BIT_CPU_EN  = 15;
  localparam int BIT_CHK_DIS = 9;
  localparam int BIT_CHK_WEN = 8;
  localparam int BIT_READY   = 3;
  localparam int BIT_PROG_OK = 2;
  localparam int BIT_DONE    = 1;
  localparam int BIT_ERR_DET = 17;

  function automatic logic [DATA_W-1:0] unlock_key(input logic [1:0] idx);
    case (idx)
      2'd0:    return 32'h0000_000F;
      2'd1:    return 32'h0000_0004;
      2'd2:    return 32'h0000_0008;
      default: return 32'h0000_000D;
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] new_bits(input logic [DATA_W-1:0] data,
                                                input logic [CHK_W-1:0] chk,
                                                input logic chk_wen);
    return {(chk_wen ? chk : {CHK_W{1'b0}}), data};
  endfunction

  function automatic logic [ROW_W-1:0] fuse_merge(input logic [ROW_W-1:0] old_row,
                                                  input logic [ROW_W-1:0] add);
    return old_row | add;
  endfunction

  function automatic logic err_flag(input logic [CHK_W-1:0] chk, input logic chk_dis);
    return !chk_dis && (chk != '0);
  endfunction
endpackage

// File: rtl/fuse_unlock.sv
module fuse_unlock
  import fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step_valid,
  input  logic [DATA_W-1:0] key_word,
  output logic              prog_ok
);
  logic [1:0] step_q;
  logic       key_match;

  assign key_match = (key_word == unlock_key(step_q));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      step_q  <= 2'd0;
      prog_ok <= 1'b0;
    end else if (step_valid && !prog_ok) begin
      if (!key_match) begin
        step_q <= 2'd0;
      end else if (step_q == 2'd3) begin
        step_q  <= 2'd0;
        prog_ok <= 1'b1;
      end else begin
        step_q <= step_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_pkg::*;
#(
  parameter int ROWS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [RADDR_W-1:0] wr_row,
  input  logic [ROW_W-1:0]   wr_bits,
  input  logic [RADDR_W-1:0] rd_row,
  output logic [ROW_W-1:0]   rd_bits
);
  logic [ROW_W-1:0] cell_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic hit;
    assign hit = we && (wr_row == RADDR_W'(r));
    always_ff @(posedge clk) begin
      if (!rst_n)   cell_q[r] <= '0;
      else if (hit) cell_q[r] <= fuse_merge(cell_q[r], wr_bits);
    end
  end

  always_comb begin
    rd_bits = '0;
    for (int r = 0; r < ROWS; r++)
      if (rd_row == RADDR_W'(r)) rd_bits = cell_q[r];
  end
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_pkg::*;
#(
  parameter int ROWS        = 16,
  parameter int INIT_CYCLES = 8,
  parameter int CMD_CYCLES  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int INIT_W = $clog2(INIT_CYCLES) + 1;
  localparam int CNT_W  = $clog2(CMD_CYCLES) + 1;

  logic               cpu_en_q, chk_dis_q, chk_wen_q;
  logic [RADDR_W-1:0] row_q;
  logic [DATA_W-1:0]  wd0_q;
  logic [CHK_W-1:0]   wd1_q;
  logic [4:0]         cmd_q;
  logic               done_q, err_q;
  logic [DATA_W-1:0]  rd0_q;
  logic [CHK_W-1:0]   rd1_q;
  logic [INIT_W-1:0]  init_cnt_q;
  logic               ready_q, start_prev_q, busy_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [3:0]         op_cmd_q;
  logic [RADDR_W-1:0] op_row_q;
  logic [DATA_W-1:0]  op_wd0_q;
  logic [CHK_W-1:0]   op_wd1_q;
  logic               op_wen_q, op_dis_q;

  // named internal events
  logic cpu_en, launch, finish, pe_valid, arr_we, rd_evt, prog_ok;
  logic [ROW_W-1:0] arr_rd;
  logic wr_hit_stb;

  assign cpu_en     = cpu_en_q;
  assign launch     = cmd_q[0] && !start_prev_q && cpu_en_q && ready_q && !busy_q;
  assign finish     = busy_q && (cnt_q == '0);
  assign pe_valid   = finish && (op_cmd_q == CMD_PROG_EN);
  assign arr_we     = finish && (op_cmd_q == CMD_PROG_WORD) && prog_ok;
  assign rd_evt     = finish && (op_cmd_q == CMD_READ);
  assign wr_hit_stb = bus_we && (bus_addr == REG_STB) && bus_wdata[BIT_DONE];

  fuse_unlock u_unlock (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (!cpu_en_q),
    .step_valid (pe_valid),
    .key_word   (op_wd0_q),
    .prog_ok    (prog_ok)
  );

  fuse_array #(.ROWS(ROWS)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (arr_we),
    .wr_row  (op_row_q),
    .wr_bits (new_bits(op_wd0_q, op_wd1_q, op_wen_q)),
    .rd_row  (op_row_q),
    .rd_bits (arr_rd)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_en_q <= 1'b0; chk_dis_q <= 1'b0; chk_wen_q <= 1'b0;
      row_q <= '0; wd0_q <= '0; wd1_q <= '0; cmd_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        REG_ACC: begin
          cpu_en_q  <= bus_wdata[BIT_CPU_EN];
          chk_dis_q <= bus_wdata[BIT_CHK_DIS];
          chk_wen_q <= bus_wdata[BIT_CHK_WEN];
        end
        REG_ROW: row_q <= bus_wdata[RADDR_LSB +: RADDR_W];
        REG_WD0: wd0_q <= bus_wdata;
        REG_WD1: wd1_q <= bus_wdata[CHK_W-1:0];
        REG_CMD: cmd_q <= bus_wdata[4:0];
        default: ;
      endcase
    end
  end

  // initialisation timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_cnt_q <= '0;
      ready_q    <= 1'b0;
    end else if (!ready_q) begin
      if (init_cnt_q == INIT_W'(INIT_CYCLES - 1)) ready_q <= 1'b1;
      else init_cnt_q <= init_cnt_q + 1'b1;
    end
  end

  // command sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_prev_q <= 1'b0;
      busy_q <= 1'b0; cnt_q <= '0;
      op_cmd_q <= '0; op_row_q <= '0; op_wd0_q <= '0; op_wd1_q <= '0;
      op_wen_q <= 1'b0; op_dis_q <= 1'b0;
    end else begin
      start_prev_q <= cmd_q[0];
      if (launch) begin
        busy_q   <= 1'b1;
        cnt_q    <= CNT_W'(CMD_CYCLES - 1);
        op_cmd_q <= cmd_q[4:1];
        op_row_q <= row_q;
        op_wd0_q <= wd0_q;
        op_wd1_q <= wd1_q;
        op_wen_q <= chk_wen_q;
        op_dis_q <= chk_dis_q;
      end else if (finish) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // results and flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0; err_q <= 1'b0; rd0_q <= '0; rd1_q <= '0;
    end else begin
      if (finish)          done_q <= 1'b1;
      else if (wr_hit_stb) done_q <= 1'b0;
      if (rd_evt) begin
        rd0_q <= arr_rd[DATA_W-1:0];
        rd1_q <= arr_rd[ROW_W-1:DATA_W];
        err_q <= err_flag(arr_rd[ROW_W-1:DATA_W], op_dis_q);
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_ACC: begin
        bus_rdata[BIT_CPU_EN]  = cpu_en_q;
        bus_rdata[BIT_CHK_DIS] = chk_dis_q;
        bus_rdata[BIT_CHK_WEN] = chk_wen_q;
      end
      REG_ROW: bus_rdata[RADDR_LSB +: RADDR_W] = row_q;
      REG_WD0: bus_rdata = wd0_q;
      REG_WD1: bus_rdata[CHK_W-1:0] = wd1_q;
      REG_CMD: bus_rdata[4:0] = cmd_q;
      REG_ST: begin
        bus_rdata[BIT_READY]   = ready_q;
        bus_rdata[BIT_PROG_OK] = prog_ok;
      end
      REG_STB: begin
        bus_rdata[BIT_DONE]    = done_q;
        bus_rdata[BIT_ERR_DET] = err_q;
      end
      REG_RD0: bus_rdata = rd0_q;
      REG_RD1: bus_rdata[CHK_W-1:0] = rd1_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/fuse_ctrl_chk.sv
module fuse_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cpu_en,
  input logic ready,
  input logic busy,
  input logic finish,
  input logic pe_valid,
  input logic prog_ok,
  input logic done
);
  assert_no_cmd_before_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !busy);
  assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ready));
  assert_start_needs_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cpu_en));
  assert_done_after_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_finish_ends_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy);
  assert_unlock_by_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_ok) |-> $past(pe_valid));
  assert_cpu_off_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_en |=> !prog_ok);
endmodule

bind fuse_ctrl fuse_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_en   (cpu_en),
  .ready    (ready_q),
  .busy     (busy_q),
  .finish   (finish),
  .pe_valid (pe_valid),
  .prog_ok  (prog_ok),
  .done     (done_q)
);

// File: tb/tb_fuse_ctrl.sv
module tb_fuse_ctrl;
  localparam int ROWS = 16;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;
  bit finished = 0;
  logic [40:0] model [ROWS];
  logic cur_dis = 0, cur_wen = 0;
  logic [31:0] rv;

  fuse_ctrl #(.ROWS(ROWS), .INIT_CYCLES(8), .CMD_CYCLES(4)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  function automatic logic [40:0] fuse_after(logic [40:0] cur, logic [31:0] d,
                                             logic [8:0] c, logic w);
    logic [40:0] add;
    add[31:0] = d;
    add[40:32] = w ? c : 9'h000;
    return add | cur;
  endfunction

  function automatic logic exp_err(logic [8:0] c, logic dis);
    return (|c) & ~dis;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic set_acc(input logic en, input logic dis, input logic wen);
    cur_dis = dis; cur_wen = wen;
    wr(4'd0, {16'h0, en, 5'h0, dis, wen, 8'h0});
  endtask

  task automatic run_cmd(input logic [3:0] code, output bit seen);
    logic [31:0] s;
    seen = 0;
    wr(4'd4, {27'h0, code, 1'b1});
    for (int i = 0; i < 50 && !seen; i++) begin
      rd(4'd6, s);
      seen = s[1];
    end
    wr(4'd6, 32'h2);
    wr(4'd4, {27'h0, code, 1'b0});
  endtask

  task automatic do_read(input int row, output logic [31:0] d0, output logic [31:0] d1,
                         output logic err);
    bit seen;
    logic [31:0] s;
    wr(4'd1, 32'(row) << 6);
    run_cmd(4'd0, seen);
    rd(4'd7, d0); rd(4'd8, d1); rd(4'd6, s); err = s[17];
  endtask

  task automatic do_prog(input int row, input logic [31:0] d, input logic [8:0] c, input bit ok_now);
    bit seen;
    wr(4'd1, 32'(row) << 6); wr(4'd2, d); wr(4'd3, {23'h0, c});
    run_cmd(4'd10, seen);
    if (ok_now && row < ROWS) model[row] = fuse_after(model[row], d, c, cur_wen);
  endtask

  task automatic unlock_word(input logic [31:0] w);
    bit seen;
    wr(4'd2, w); run_cmd(4'd2, seen);
  endtask

  task automatic verify_row(input int row, input string req);
    logic [31:0] d0, d1; logic e; logic [40:0] m;
    m = (row < ROWS) ? model[row] : 41'h0;
    do_read(row, d0, d1, e);
    check(d0 == m[31:0], req, d0, m[31:0]);
    check(d1 == {23'h0, m[40:32]}, req, d1, {23'h0, m[40:32]});
    check(e == exp_err(m[40:32], cur_dis), {req, " R9"}, e, exp_err(m[40:32], cur_dis));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit seen;
    void'($urandom(32'd4242));
    for (int r = 0; r < ROWS; r++) model[r] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: not ready right after reset, early start ignored
    rd(4'd5, rv);
    check(rv[3] == 1'b0, "R1 ready low after reset", rv, 0);
    set_acc(1, 0, 1);
    wr(4'd4, 32'h1);
    repeat (20) @(negedge clk);
    rd(4'd5, rv);
    check(rv[3] == 1'b1, "R1 ready later", rv[3], 1);
    rd(4'd6, rv);
    check(rv[1] == 1'b0, "R1 no command before ready", rv[1], 0);
    wr(4'd4, 32'h0);
    // R4/R11: unprogrammed read
    verify_row(3, "R4 blank row");
    // R7: program while locked
    do_prog(2, 32'hFFFF_0001, 9'h1FF, 0);
    verify_row(2, "R7 locked program");
    // R3: done from command, start held high does not relaunch
    wr(4'd4, 32'h1);
    repeat (15) @(negedge clk);
    rd(4'd6, rv);
    check(rv[1] == 1'b1, "R3 done after start", rv[1], 1);
    wr(4'd6, 32'h2);
    repeat (15) @(negedge clk);
    rd(4'd6, rv);
    check(rv[1] == 1'b0, "R3 done cleared, no relaunch", rv[1], 0);
    wr(4'd4, 32'h0);
    // R2: cpu access off
    set_acc(0, 0, 1);
    wr(4'd4, 32'h1);
    repeat (15) @(negedge clk);
    rd(4'd6, rv);
    check(rv[1] == 1'b0, "R2 start ignored when access off", rv[1], 0);
    wr(4'd4, 32'h0);
    set_acc(1, 0, 1);
    // R5: wrong sequences
    unlock_word(32'hF); unlock_word(32'h4); unlock_word(32'h9); unlock_word(32'hD);
    rd(4'd5, rv);
    check(rv[2] == 1'b0, "R5 bad third word", rv[2], 0);
    unlock_word(32'hF); unlock_word(32'h4); unlock_word(32'hF);
    unlock_word(32'h4); unlock_word(32'h8); unlock_word(32'hD);
    rd(4'd5, rv);
    check(rv[2] == 1'b0, "R5 restart on wrong word", rv[2], 0);
    unlock_word(32'hF); unlock_word(32'h4); unlock_word(32'h8); unlock_word(32'hD);
    rd(4'd5, rv);
    check(rv[2] == 1'b1, "R5 unlocked", rv[2], 1);
    // R8/R9
    do_prog(5, 32'hA5A5_0F0F, 9'h155, 1);
    verify_row(5, "R8 first program");
    set_acc(1, 1, 0);
    verify_row(5, "R9 check disabled");
    do_prog(5, 32'h0000_F0F0, 9'h0AA, 1);
    set_acc(1, 0, 0);
    verify_row(5, "R8 OR and check bits kept");
    // R10
    do_prog(20, 32'hFFFF_FFFF, 9'h1FF, 1);
    verify_row(20, "R10 out of range");
    // random mix
    for (int i = 0; i < 40; i++) begin
      int row;
      row = int'($urandom_range(0, 19));
      set_acc(1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 1) == 1)
        do_prog(row, $urandom & $urandom, 9'($urandom & $urandom), 1);
      else
        verify_row(row, "R8 random read");
    end
    // R6: access off clears unlock
    set_acc(0, 0, 1);
    set_acc(1, 0, 1);
    rd(4'd5, rv);
    check(rv[2] == 1'b0, "R6 program-OK cleared", rv[2], 0);
    do_prog(1, 32'h1234_5678, 9'h0F0, 0);
    verify_row(1, "R6 relocked row unchanged");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule